// File: doc/BRIEF.md
# Pin Change Interrupt Generator

This block raises an active-low interrupt request for a parallel I/O expander with several byte-wide ports. Every clock cycle it compares the synchronized level of each pin against the value last captured into the readable input register. Only pins whose direction bit marks them as inputs take part in the comparison. Any difference pulls the interrupt line low. The line output is a drive-low enable: the pad pulls the wire low while the enable is 1 and releases it otherwise. An external pull-up gives the inactive level.

Each port keeps its own pending state. A read-acknowledge pulse for a port clears that port only. A bus Stop pulse clears every port. After a clear, a mismatch that simply persists does not raise the request again. A pin that goes back to its captured value withdraws its contribution without any help. A later change on that pin is then detected once more. A pin that is switched from output to input while it differs from its captured value counts as a fresh change.

Top module: `pin_change_irq`

## Requirements
- R1: A pin with its direction bit at 1 (input) whose level differs from its captured value, with no clear pending, makes `irq_pull_o` 1 after the next rising clock edge.
- R2: A pin with its direction bit at 0 (output) never causes `irq_pull_o` to be 1, whatever its level.
- R3: When no input-direction pin differs from its captured value, `irq_pull_o` is 0 after the next rising edge, with no read or Stop needed.
- R4: `port_rd_ack_i[p]` clears only port p. Port p covers pins `[8p+7:8p]` in the default configuration. A pending state on another port keeps `irq_pull_o` at 1.
- R5: A one-cycle `bus_stop_i` pulse clears the pending state of every port, so `irq_pull_o` is 0 after that edge.
- R6: After a clear, a mismatch that stays unchanged (same pins, snapshot and directions) does not set `irq_pull_o` again.
- R7: After a clear, a change on a different pin is detected and sets `irq_pull_o`. A pin that returned to its captured value and then differs again is also detected and sets `irq_pull_o`.
- R8: Changing a direction bit from 0 to 1 on a pin whose level differs from its captured value sets `irq_pull_o` after the next edge.
- R9: While `rst_ni` is 0, `irq_pull_o` is 0 at once (asynchronously). Every pending state is cleared.
- R10: `irq_pull_o` is a registered output. A change at the inputs shows up only after one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | NUM_PORTS*PORT_W | Synchronized pin levels |
| in_snap_i | input | NUM_PORTS*PORT_W | Captured input-register value |
| dir_in_i | input | NUM_PORTS*PORT_W | Direction mask, 1 = input |
| port_rd_ack_i | input | NUM_PORTS | Per-port read-acknowledge pulse |
| bus_stop_i | input | 1 | Bus Stop pulse, clears all ports |
| irq_pull_o | output | 1 | Drive-low enable for the open-drain interrupt line |

## Verification
The bench uses the default configuration: two ports of eight pins. This puts the byte boundary between pins 7 and 8 in play. It also lets one port's read be checked for leaving the other port's pending state alone. With two ports, the Stop pulse can be shown to clear both ports at once. The sequences cover the interrupt being withdrawn when a pin returns to its captured value. They cover detection again after that, and a pin turned from output to input while it differs from its captured value.

// File: rtl/pci_pkg.sv
package pci_pkg;
  localparam int unsigned DEF_PORT_W    = 8;
  localparam int unsigned DEF_NUM_PORTS = 2;
endpackage

// File: rtl/pci_mismatch.sv
module pci_mismatch #(
  parameter int unsigned PORT_W = 8
) (
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] snap_i,
  input  logic [PORT_W-1:0] dir_i,
  output logic [PORT_W-1:0] diff_o
);
  // only input-direction pins may differ
  always_comb diff_o = (pin_i ^ snap_i) & dir_i;
endmodule

// File: rtl/pci_port_flag.sv
module pci_port_flag #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] diff_i,
  input  logic              clr_i,
  output logic              pend_o
);
  // acked_q: differing bits already acknowledged by the last clear
  logic [PORT_W-1:0] acked_q, acked_d;
  logic              pend_q, pend_d;

  always_comb begin
    if (clr_i) begin
      acked_d = diff_i;
      pend_d  = 1'b0;
    end else begin
      // bits that returned leave the acked set so a later change refires
      acked_d = acked_q & diff_i;
      pend_d  = |(diff_i & ~acked_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acked_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      acked_q <= acked_d;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pci_irq_merge.sv
module pci_irq_merge #(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic [NUM_PORTS-1:0] pend_i,
  output logic                 irq_o
);
  always_comb irq_o = |pend_i;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned PORT_W    = pci_pkg::DEF_PORT_W,
  parameter int unsigned NUM_PORTS = pci_pkg::DEF_NUM_PORTS,
  localparam int unsigned PIN_W    = PORT_W * NUM_PORTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_W-1:0]     pin_lvl_i,
  input  logic [PIN_W-1:0]     in_snap_i,
  input  logic [PIN_W-1:0]     dir_in_i,
  input  logic [NUM_PORTS-1:0] port_rd_ack_i,
  input  logic                 bus_stop_i,
  output logic                 irq_pull_o
);
  logic [NUM_PORTS-1:0] pend;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] diff;
    logic              clr;

    pci_mismatch #(.PORT_W(PORT_W)) u_mm (
      .pin_i  (pin_lvl_i[p*PORT_W +: PORT_W]),
      .snap_i (in_snap_i[p*PORT_W +: PORT_W]),
      .dir_i  (dir_in_i[p*PORT_W +: PORT_W]),
      .diff_o (diff)
    );

    assign clr = port_rd_ack_i[p] | bus_stop_i;

    pci_port_flag #(.PORT_W(PORT_W)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .diff_i (diff),
      .clr_i  (clr),
      .pend_o (pend[p])
    );
  end

  pci_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
    .pend_i (pend),
    .irq_o  (irq_pull_o)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2,
  localparam int unsigned PIN_W    = PORT_W * NUM_PORTS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [PIN_W-1:0]     pin_lvl_i,
  input logic [PIN_W-1:0]     in_snap_i,
  input logic [PIN_W-1:0]     dir_in_i,
  input logic [NUM_PORTS-1:0] port_rd_ack_i,
  input logic                 bus_stop_i,
  input logic                 irq_pull_o
);
  logic [PIN_W-1:0] mm;
  assign mm = (pin_lvl_i ^ in_snap_i) & dir_in_i;

  assert_fresh_change_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm == '0) ##1 ((mm != '0) && (port_rd_ack_i == '0) && !bus_stop_i) |=> irq_pull_o);

  assert_outputs_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_in_i == '0) |=> !irq_pull_o);

  assert_self_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm == '0) |=> !irq_pull_o);

  assert_read_all_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&port_rd_ack_i) |=> !irq_pull_o);

  assert_stop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stop_i |=> !irq_pull_o);

  assert_stable_no_refire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stop_i ##1 ($stable(pin_lvl_i) && $stable(in_snap_i) && $stable(dir_in_i)
      && !bus_stop_i && (port_rd_ack_i == '0)) |=> !irq_pull_o);

  assert_reset_release_R9: assert property (@(posedge clk_i) !rst_ni |-> !irq_pull_o);
endmodule

bind pin_change_irq pin_change_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pin_lvl_i     (pin_lvl_i),
  .in_snap_i     (in_snap_i),
  .dir_in_i      (dir_in_i),
  .port_rd_ack_i (port_rd_ack_i),
  .bus_stop_i    (bus_stop_i),
  .irq_pull_o    (irq_pull_o)
);

// File: tb/pin_change_irq_bench.sv
`timescale 1ns/1ps
module pin_change_irq_bench;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned NPORT  = 2;
  localparam int unsigned PW     = PORT_W * NPORT;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PW-1:0]    pins = '0, snap = '0, dir = '1;
  logic [NPORT-1:0] ack = '0;
  logic             stp = 1'b0;
  logic             irq;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .pin_lvl_i     (pins),
    .in_snap_i     (snap),
    .dir_in_i      (dir),
    .port_rd_ack_i (ack),
    .bus_stop_i    (stp),
    .irq_pull_o    (irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_pull_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the result expected after the edge
  task automatic step(input logic [PW-1:0] p, input logic [PW-1:0] s,
                      input logic [PW-1:0] d, input logic [NPORT-1:0] a,
                      input logic st, input logic exp, input string tag);
    @(negedge clk);
    pins = p; snap = s; dir = d; ack = a; stp = st;
    sb_q.push_back('{exp, tag});
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(irq, it.exp, it.tag);
      end
    end
  end

  initial begin
    #1;
    check(irq, 1'b0, "R9 reset state");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(16'h0000, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R3 idle equal");
    step(16'h0001, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R1 R10 pin0 rise");
    step(16'h0000, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R3 pin0 returns");
    step(16'h0001, 16'h0000, 16'hFFFE, 2'b00, 0, 0, "R2 output pin0 masked");
    step(16'hFF01, 16'h0000, 16'h00FE, 2'b00, 0, 0, "R2 output port1 masked");
    step(16'h0001, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R8 dir out->in mismatch");
    step(16'h0001, 16'h0000, 16'hFFFF, 2'b00, 1, 0, "R5 stop clears");
    step(16'h0001, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R6 stable after stop");
    step(16'h0001, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R6 stable again");
    step(16'h0003, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R7 new pin after clear");
    step(16'h0003, 16'h0000, 16'hFFFF, 2'b01, 0, 0, "R4 read port0 clears");
    step(16'h0003, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R6 stable after read");
    step(16'h0103, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R1 pin8 port1");
    step(16'h0103, 16'h0000, 16'hFFFF, 2'b01, 0, 1, "R4 port0 read keeps port1");
    step(16'h0103, 16'h0000, 16'hFFFF, 2'b10, 0, 0, "R4 port1 read clears");
    step(16'h0102, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R7 pin0 returns quietly");
    step(16'h0103, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R7 pin0 differs again");
    step(16'h0103, 16'h0103, 16'hFFFF, 2'b00, 0, 0, "R3 snapshot catches up");
    step(16'h8080, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R1 both ports");
    step(16'h8080, 16'h0000, 16'hFFFF, 2'b00, 1, 0, "R5 stop clears both");
    step(16'h8080, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R6 both stable");
    step(16'h0080, 16'h0000, 16'hFFFF, 2'b00, 0, 0, "R3 pin15 returns");
    step(16'h8080, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R7 pin15 again");
    step(16'h8080, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R1 held pending");

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(irq, 1'b0, "R9 async release");
    @(negedge clk);
    rst_n = 1'b1;
    step(16'h8080, 16'h0000, 16'hFFFF, 2'b00, 0, 1, "R9 R1 fresh after reset");
    step(16'h8080, 16'h8080, 16'hFFFF, 2'b00, 0, 0, "R3 final equal");
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule